// File: doc/BRIEF.md
# Scoreboard Hazard Controller

This block is the central out-of-order control point for a group of five execution units: one integer unit, two multipliers, one adder and one divider. Each cycle it may accept one decoded instruction (operation code, destination register, two source registers). It then steers that instruction through four steps: issue, operand read, execution and result write. It grants issue in program order. It tells a unit when both of its sources can be read. It takes a completion pulse from each unit and decides which finished unit may write its result.

Each unit has its own status record: busy, operation, destination, both source register numbers, the producing unit for each source, and a ready flag for each source. A result table holds, for every register, the unit that will write it, if any. From these records the block resolves three kinds of hazard. Structural and write-after-write conflicts stall issue. Read-after-write conflicts hold the operand read. Write-after-read conflicts hold the result write. The block moves no data. It produces the go and grant signals that a register file and the units act on.

Top module: `sb_hazard_ctl`

## Requirements
- R1: After reset no unit is busy, no read-go is raised and no write-back is granted.
- R2: Operation codes map to units as follows. Codes 0 and 1 go to the integer unit (index 0). Code 2 goes to a multiplier (index 1 or 2, lowest free index first). Codes 3 and 4 go to the adder (index 3). Codes 5 to 7 go to the divider (index 4). A grant reports the chosen index on `iss_fu`.
- R3: Issue is refused in any cycle in which every unit able to run the presented code is busy.
- R4: Issue is refused while any active instruction targets the same destination register. It can be granted no earlier than the cycle after that instruction's write-back.
- R5: A unit gets exactly one read-go cycle, and only when both sources are available. A source produced by a pending unit becomes available so that the read-go appears in the cycle right after that unit's write-back.
- R6: A later instruction whose sources are ready reads its operands before an earlier instruction that is still waiting on a source.
- R7: A finished unit does not write back while another unit still has an unread source equal to its destination. It writes in the cycle after that reader's read-go.
- R8: At most one write-back is granted per cycle. When several units want to write, the lowest index wins, and the loser writes in the next cycle.
- R9: An instruction issued in the same cycle as the write-back of the producer of one of its sources treats that source as available. It gets its read-go in the next cycle.
- R10: While a unit is busy, its 3-bit slice of `fu_op` (unit u at bits 3u+2..3u) holds the operation code it was issued with.
- R11: A completion pulse to a unit that is idle or still waiting for operands has no effect. No write-back results from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | A decoded instruction is presented |
| iss_op | input | 3 | Operation code of the presented instruction |
| iss_dst | input | RW | Destination register |
| iss_src1 | input | RW | First source register |
| iss_src2 | input | RW | Second source register |
| iss_grant | output | 1 | Presented instruction issues at this clock edge |
| iss_fu | output | 3 | Unit index chosen for the issued instruction |
| rd_go | output | 5 | Per unit: read operands and start executing now |
| fu_op | output | 15 | Per unit operation code, 3 bits per unit |
| ex_done | input | 5 | Per unit completion pulse |
| wb_valid | output | 1 | A write-back is granted this cycle |
| wb_fu | output | 3 | Unit granted the write-back |
| wb_dst | output | RW | Register written by the granted unit |

## Verification
The hardest situation to reach from the ports is a finished unit that is held back purely by a write-after-read conflict. A reader must be stuck waiting on an unrelated long-latency producer, and its other, already-available source must name the destination of a fast unit issued after it. The bench builds this by issuing a slow multiply, then a divide that needs the multiply result and also reads the register the adder is about to overwrite, then a one-cycle add. The bench then checks that the add writes exactly one cycle after the divide reads. The same-cycle issue-during-write-back case is reached by holding a unit's completion under manual control. This places the write-back cycle exactly where the dependent instruction is presented.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int NUM_FU = 5;
  localparam int FU_W   = 3;
  localparam int OPC_W  = 3;

  localparam int FU_INT  = 0;
  localparam int FU_MUL0 = 1;
  localparam int FU_MUL1 = 2;
  localparam int FU_ADD  = 3;
  localparam int FU_DIV  = 4;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_WAIT_OPS = 2'd1,
    ST_EXEC     = 2'd2,
    ST_WAIT_WB  = 2'd3
  } fu_state_e;

  // Units able to run a given operation code (R2)
  function automatic logic [NUM_FU-1:0] class_mask(input logic [OPC_W-1:0] opc);
    logic [NUM_FU-1:0] m;
    m = '0;
    case (opc)
      3'd0, 3'd1: m[FU_INT] = 1'b1;
      3'd2: begin
        m[FU_MUL0] = 1'b1;
        m[FU_MUL1] = 1'b1;
      end
      3'd3, 3'd4: m[FU_ADD] = 1'b1;
      default: m[FU_DIV] = 1'b1;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/sb_fu_entry.sv
// Status record and step sequencer of one execution unit.
module sb_fu_entry
  import sb_pkg::*;
#(
  parameter int RW    = 5,
  parameter int OP_W  = OPC_W,
  parameter int TAG_W = FU_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic [OP_W-1:0]  alloc_op,
  input  logic [RW-1:0]    alloc_fi,
  input  logic [RW-1:0]    alloc_fj,
  input  logic [RW-1:0]    alloc_fk,
  input  logic [TAG_W-1:0] alloc_qj,
  input  logic [TAG_W-1:0] alloc_qk,
  input  logic             alloc_rj,
  input  logic             alloc_rk,
  input  logic             ex_done,
  input  logic             wb_grant,
  input  logic             bc_valid,
  input  logic [TAG_W-1:0] bc_fu,
  output logic             busy,
  output logic             rd_go,
  output logic             wb_want,
  output logic [OP_W-1:0]  op,
  output logic [RW-1:0]    fi,
  output logic [RW-1:0]    fj,
  output logic [RW-1:0]    fk,
  output logic             rj,
  output logic             rk
);

  fu_state_e        st_q, st_d;
  logic             rj_q, rj_d, rk_q, rk_d;
  logic             load_en;
  logic [OP_W-1:0]  op_q;
  logic [RW-1:0]    fi_q, fj_q, fk_q;
  logic [TAG_W-1:0] qj_q, qk_q;

  // Next-state logic
  always_comb begin
    st_d    = st_q;
    rj_d    = rj_q;
    rk_d    = rk_q;
    load_en = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (alloc) begin
          st_d    = ST_WAIT_OPS;
          rj_d    = alloc_rj;
          rk_d    = alloc_rk;
          load_en = 1'b1;
        end
      end
      ST_WAIT_OPS: begin
        if (rj_q && rk_q) begin
          // operands taken this cycle (R5); flags drop once read
          st_d = ST_EXEC;
          rj_d = 1'b0;
          rk_d = 1'b0;
        end else begin
          if (bc_valid && !rj_q && (bc_fu == qj_q)) rj_d = 1'b1;
          if (bc_valid && !rk_q && (bc_fu == qk_q)) rk_d = 1'b1;
        end
      end
      ST_EXEC: begin
        if (ex_done) st_d = ST_WAIT_WB;  // completion honoured only here (R11)
      end
      ST_WAIT_WB: begin
        if (wb_grant) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      rj_q <= 1'b0;
      rk_q <= 1'b0;
    end else begin
      st_q <= st_d;
      rj_q <= rj_d;
      rk_q <= rk_d;
    end
  end

  // Record fields, loaded under the allocation enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= '0;
      fi_q <= '0;
      fj_q <= '0;
      fk_q <= '0;
      qj_q <= '0;
      qk_q <= '0;
    end else if (load_en) begin
      op_q <= alloc_op;
      fi_q <= alloc_fi;
      fj_q <= alloc_fj;
      fk_q <= alloc_fk;
      qj_q <= alloc_qj;
      qk_q <= alloc_qk;
    end
  end

  assign busy    = (st_q != ST_IDLE);
  assign rd_go   = (st_q == ST_WAIT_OPS) && rj_q && rk_q;
  assign wb_want = (st_q == ST_WAIT_WB);
  assign op      = op_q;
  assign fi      = fi_q;
  assign fj      = fj_q;
  assign fk      = fk_q;
  assign rj      = rj_q;
  assign rk      = rk_q;

endmodule

// File: rtl/sb_issue_ctl.sv
// In-order issue: unit selection, structural and WAW checks.
module sb_issue_ctl
  import sb_pkg::*;
#(
  parameter int N     = NUM_FU,
  parameter int TAG_W = FU_W,
  parameter int OP_W  = OPC_W
) (
  input  logic             iss_valid,
  input  logic [OP_W-1:0]  iss_op,
  input  logic             dst_pend,
  input  logic [N-1:0]     fu_busy,
  output logic             iss_grant,
  output logic [TAG_W-1:0] iss_fu,
  output logic [N-1:0]     alloc
);

  logic [N-1:0] cand;
  logic         any_free;

  always_comb begin
    cand     = class_mask(iss_op) & ~fu_busy;
    any_free = |cand;
    iss_fu   = '0;
    // lowest free index of the class wins (R2)
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) iss_fu = TAG_W'(i);
    end
    // structural stall (R3) and WAW stall (R4)
    iss_grant = iss_valid && any_free && !dst_pend;
    alloc     = iss_grant ? (N'(1) << iss_fu) : '0;
  end

endmodule

// File: rtl/sb_wb_arb.sv
// Fixed-priority write-back arbiter, lowest index first (R8).
module sb_wb_arb #(
  parameter int N     = 5,
  parameter int TAG_W = 3
) (
  input  logic [N-1:0]     req,
  output logic [N-1:0]     gnt,
  output logic             valid,
  output logic [TAG_W-1:0] idx
);

  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar g = 0; g < N; g++) begin : g_pri
    assign gnt[g]    = req[g] & ~seen[g];
    assign seen[g+1] = seen[g] | req[g];
  end

  assign valid = seen[N];

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (gnt[i]) idx = TAG_W'(i);
    end
  end

endmodule

// File: rtl/sb_hazard_ctl.sv
// Centralized scoreboard: unit records, register result table, hazard checks.
module sb_hazard_ctl
  import sb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int RW       = $clog2(NUM_REGS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     iss_valid,
  input  logic [OPC_W-1:0]         iss_op,
  input  logic [RW-1:0]            iss_dst,
  input  logic [RW-1:0]            iss_src1,
  input  logic [RW-1:0]            iss_src2,
  output logic                     iss_grant,
  output logic [FU_W-1:0]          iss_fu,
  output logic [NUM_FU-1:0]        rd_go,
  output logic [NUM_FU*OPC_W-1:0]  fu_op,
  input  logic [NUM_FU-1:0]        ex_done,
  output logic                     wb_valid,
  output logic [FU_W-1:0]          wb_fu,
  output logic [RW-1:0]            wb_dst
);

  logic [NUM_FU-1:0]             fu_busy, fu_alloc, fu_wb_want, fu_rj, fu_rk;
  logic [NUM_FU-1:0]             wb_req, wb_gnt;
  logic [NUM_FU-1:0][RW-1:0]     fu_fi, fu_fj, fu_fk;
  logic [NUM_FU-1:0][OPC_W-1:0]  fu_opc;

  logic [NUM_REGS-1:0]            res_pend, res_pend_d;
  logic [NUM_REGS-1:0][FU_W-1:0]  res_fu, res_fu_d;

  logic [FU_W-1:0] src1_tag, src2_tag;
  logic            src1_rdy, src2_rdy;

  // Source lookup: a producer writing back this very cycle counts as done (R9)
  assign src1_tag = res_fu[iss_src1];
  assign src2_tag = res_fu[iss_src2];
  assign src1_rdy = !res_pend[iss_src1] || (wb_valid && (wb_fu == src1_tag));
  assign src2_rdy = !res_pend[iss_src2] || (wb_valid && (wb_fu == src2_tag));

  sb_issue_ctl #(
    .N    (NUM_FU),
    .TAG_W(FU_W),
    .OP_W (OPC_W)
  ) u_issue (
    .iss_valid(iss_valid),
    .iss_op   (iss_op),
    .dst_pend (res_pend[iss_dst]),
    .fu_busy  (fu_busy),
    .iss_grant(iss_grant),
    .iss_fu   (iss_fu),
    .alloc    (fu_alloc)
  );

  for (genvar g = 0; g < NUM_FU; g++) begin : g_unit
    sb_fu_entry #(
      .RW   (RW),
      .OP_W (OPC_W),
      .TAG_W(FU_W)
    ) u_entry (
      .clk     (clk),
      .rst_n   (rst_n),
      .alloc   (fu_alloc[g]),
      .alloc_op(iss_op),
      .alloc_fi(iss_dst),
      .alloc_fj(iss_src1),
      .alloc_fk(iss_src2),
      .alloc_qj(src1_tag),
      .alloc_qk(src2_tag),
      .alloc_rj(src1_rdy),
      .alloc_rk(src2_rdy),
      .ex_done (ex_done[g]),
      .wb_grant(wb_gnt[g]),
      .bc_valid(wb_valid),
      .bc_fu   (wb_fu),
      .busy    (fu_busy[g]),
      .rd_go   (rd_go[g]),
      .wb_want (fu_wb_want[g]),
      .op      (fu_opc[g]),
      .fi      (fu_fi[g]),
      .fj      (fu_fj[g]),
      .fk      (fu_fk[g]),
      .rj      (fu_rj[g]),
      .rk      (fu_rk[g])
    );
    assign fu_op[g*OPC_W +: OPC_W] = fu_opc[g];  // R10
  end

  // WAR check: an unread source flag implies the reader is still waiting (R7)
  always_comb begin
    for (int u = 0; u < NUM_FU; u++) begin
      logic blk;
      blk = 1'b0;
      for (int v = 0; v < NUM_FU; v++) begin
        if (v != u) begin
          if ((fu_rj[v] && (fu_fj[v] == fu_fi[u])) ||
              (fu_rk[v] && (fu_fk[v] == fu_fi[u]))) begin
            blk = 1'b1;
          end
        end
      end
      wb_req[u] = fu_wb_want[u] && !blk;
    end
  end

  sb_wb_arb #(
    .N    (NUM_FU),
    .TAG_W(FU_W)
  ) u_arb (
    .req  (wb_req),
    .gnt  (wb_gnt),
    .valid(wb_valid),
    .idx  (wb_fu)
  );

  assign wb_dst = fu_fi[wb_fu];

  // Register result table: next state
  always_comb begin
    res_pend_d = res_pend;
    res_fu_d   = res_fu;
    if (wb_valid) res_pend_d[wb_dst] = 1'b0;
    if (iss_grant) begin
      res_pend_d[iss_dst] = 1'b1;
      res_fu_d[iss_dst]   = iss_fu;
    end
  end

  // Register result table: registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_pend <= '0;
      res_fu   <= '0;
    end else begin
      res_pend <= res_pend_d;
      res_fu   <= res_fu_d;
    end
  end

endmodule

// File: rtl/sb_hazard_ctl_chk.sv
module sb_hazard_ctl_chk
  import sb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int RW       = 5
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      iss_valid,
  input logic [RW-1:0]             iss_dst,
  input logic                      iss_grant,
  input logic [FU_W-1:0]           iss_fu,
  input logic [NUM_FU-1:0]         rd_go,
  input logic                      wb_valid,
  input logic [FU_W-1:0]           wb_fu,
  input logic [RW-1:0]             wb_dst,
  input logic [NUM_FU-1:0]         fu_busy,
  input logic [NUM_REGS-1:0]       res_pend,
  input logic [NUM_FU-1:0]         fu_rj,
  input logic [NUM_FU-1:0]         fu_rk,
  input logic [NUM_FU-1:0][RW-1:0] fu_fj,
  input logic [NUM_FU-1:0][RW-1:0] fu_fk
);

  logic war_hit;
  always_comb begin
    war_hit = 1'b0;
    for (int v = 0; v < NUM_FU; v++) begin
      if ((fu_rj[v] && (fu_fj[v] == wb_dst)) || (fu_rk[v] && (fu_fk[v] == wb_dst)))
        war_hit = 1'b1;
    end
  end

  p_issue_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_grant) |-> !fu_busy[iss_fu]);

  p_issue_no_waw_r4: assert property (@(posedge clk) disable iff (!rst_n)
    iss_grant |-> !res_pend[iss_dst]);

  p_wb_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> !res_pend[$past(wb_dst)]);

  p_war_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> !war_hit);

  p_wb_from_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> fu_busy[wb_fu]);

  for (genvar g = 0; g < NUM_FU; g++) begin : g_rd
    p_read_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_go[g] |=> !rd_go[g]);
  end

endmodule

bind sb_hazard_ctl sb_hazard_ctl_chk #(
  .NUM_REGS(NUM_REGS),
  .RW      (RW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .iss_valid(iss_valid),
  .iss_dst  (iss_dst),
  .iss_grant(iss_grant),
  .iss_fu   (iss_fu),
  .rd_go    (rd_go),
  .wb_valid (wb_valid),
  .wb_fu    (wb_fu),
  .wb_dst   (wb_dst),
  .fu_busy  (fu_busy),
  .res_pend (res_pend),
  .fu_rj    (fu_rj),
  .fu_rk    (fu_rk),
  .fu_fj    (fu_fj),
  .fu_fk    (fu_fk)
);

// File: tb/tb_sb_hazard_ctl.sv
`timescale 1ns/1ps
module tb_sb_hazard_ctl;

  logic        clk;
  logic        rst_n;
  logic        iss_valid;
  logic [2:0]  iss_op;
  logic [4:0]  iss_dst, iss_src1, iss_src2;
  logic        iss_grant;
  logic [2:0]  iss_fu;
  logic [4:0]  rd_go;
  logic [14:0] fu_op;
  logic [4:0]  ex_done;
  logic        wb_valid;
  logic [2:0]  wb_fu;
  logic [4:0]  wb_dst;

  logic [4:0] auto_done, man_done;
  int lat [5];
  int cnt [5];
  int rd_cyc [5];
  int wb_cyc [5];
  int q_fu [$];
  int q_dst [$];
  int n_cmp, n_bad, cyc;
  bit finished;

  assign ex_done = auto_done | man_done;

  sb_hazard_ctl dut (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
    .iss_dst(iss_dst), .iss_src1(iss_src1), .iss_src2(iss_src2),
    .iss_grant(iss_grant), .iss_fu(iss_fu), .rd_go(rd_go), .fu_op(fu_op),
    .ex_done(ex_done), .wb_valid(wb_valid), .wb_fu(wb_fu), .wb_dst(wb_dst)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Unit model: variable latency after read-go; lat 0 means manual completion
  always @(negedge clk) begin
    for (int u = 0; u < 5; u++) begin
      auto_done[u] = 1'b0;
      if (cnt[u] > 0) begin
        cnt[u]--;
        if (cnt[u] == 0) auto_done[u] = 1'b1;
      end
      if (rst_n && rd_go[u]) begin
        rd_cyc[u] = cyc;
        if (lat[u] > 0) cnt[u] = lat[u];
      end
    end
  end

  // Monitor: pops expected write-backs and compares
  always @(negedge clk) begin
    if (rst_n && wb_valid) begin
      wb_cyc[wb_fu] = cyc;
      if (q_fu.size() == 0) begin
        chk(0, "R8", "unexpected write-back unit", int'(wb_fu), -1);
      end else begin
        int efu, edst;
        efu  = q_fu.pop_front();
        edst = q_dst.pop_front();
        chk(int'(wb_fu) == efu, "R8", "write-back unit", int'(wb_fu), efu);
        chk(int'(wb_dst) == edst, "R4", "write-back register", int'(wb_dst), edst);
      end
    end
  end

  task automatic expect_wb(input int fu, input int dst);
    q_fu.push_back(fu);
    q_dst.push_back(dst);
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic present(input int op, input int dst, input int s1, input int s2);
    iss_valid = 1'b1;
    iss_op    = 3'(op);
    iss_dst   = 5'(dst);
    iss_src1  = 5'(s1);
    iss_src2  = 5'(s2);
  endtask

  task automatic do_issue(input int op, input int dst, input int s1, input int s2,
                          input int exp_fu, input string req);
    present(op, dst, s1, s2);
    #0.5;
    chk(iss_grant == 1'b1, req, "issue grant", int'(iss_grant), 1);
    chk(int'(iss_fu) == exp_fu, req, "issued unit", int'(iss_fu), exp_fu);
    @(posedge clk);
    #0.5;
    iss_valid = 1'b0;
    tick();
  endtask

  task automatic drain();
    int i;
    for (i = 0; i < 500 && q_fu.size() != 0; i++) tick();
    chk(q_fu.size() == 0, "R8", "pending write-backs after drain", q_fu.size(), 0);
    repeat (3) tick();
  endtask

  initial begin
    int got;
    n_cmp = 0; n_bad = 0; cyc = 0; finished = 0;
    rst_n = 1'b0; iss_valid = 1'b0; iss_op = '0;
    iss_dst = '0; iss_src1 = '0; iss_src2 = '0;
    man_done = '0; auto_done = '0;
    for (int u = 0; u < 5; u++) begin
      lat[u] = 2; cnt[u] = 0; rd_cyc[u] = -100; wb_cyc[u] = -100;
    end
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    tick();

    // R1: quiet after reset
    chk(iss_grant == 1'b0, "R1", "grant without request", int'(iss_grant), 0);
    chk(rd_go == 5'b0, "R1", "read-go after reset", int'(rd_go), 0);
    chk(wb_valid == 1'b0, "R1", "write-back after reset", int'(wb_valid), 0);

    // R2 / R3 / R10: fill every unit, then try to issue into busy classes
    for (int u = 0; u < 5; u++) lat[u] = 8;
    expect_wb(0, 1); expect_wb(1, 2); expect_wb(2, 3); expect_wb(3, 4); expect_wb(4, 5);
    do_issue(0, 1, 10, 11, 0, "R2");
    do_issue(2, 2, 10, 11, 1, "R2");
    do_issue(2, 3, 10, 11, 2, "R2");
    do_issue(4, 4, 10, 11, 3, "R2");
    do_issue(5, 5, 10, 11, 4, "R2");
    chk(fu_op[14:12] == 3'd5, "R10", "divider op code", int'(fu_op[14:12]), 5);
    chk(fu_op[11:9] == 3'd4, "R10", "adder op code", int'(fu_op[11:9]), 4);
    present(2, 6, 10, 11);
    #0.5;
    chk(iss_grant == 1'b0, "R3", "grant with both multipliers busy", int'(iss_grant), 0);
    present(1, 6, 10, 11);
    #0.5;
    chk(iss_grant == 1'b0, "R3", "grant with integer unit busy", int'(iss_grant), 0);
    iss_valid = 1'b0;
    drain();

    // R4: WAW stall until the cycle after the earlier writer's write-back
    lat[3] = 10; lat[0] = 2;
    expect_wb(3, 7);
    do_issue(3, 7, 10, 11, 3, "R4");
    present(0, 7, 10, 11);
    got = 0;
    for (int i = 0; i < 60 && got == 0; i++) begin
      #0.5;
      if (iss_grant) begin
        got = 1;
        chk(cyc == wb_cyc[3] + 1, "R4", "WAW release cycle", cyc, wb_cyc[3] + 1);
        expect_wb(0, 7);
        @(posedge clk);
        #0.5;
        iss_valid = 1'b0;
      end
      tick();
    end
    iss_valid = 1'b0;
    chk(got == 1, "R4", "WAW stalled instruction issued", got, 1);
    drain();

    // R5 / R6: dependent divide waits, independent integer op reads first
    lat[3] = 12; lat[4] = 2; lat[0] = 2;
    expect_wb(0, 12); expect_wb(3, 8); expect_wb(4, 9);
    do_issue(3, 8, 10, 11, 3, "R5");
    do_issue(5, 9, 8, 10, 4, "R5");
    do_issue(0, 12, 10, 11, 0, "R6");
    chk(rd_go[0] == 1'b1, "R6", "independent read-go", int'(rd_go[0]), 1);
    chk(rd_go[4] == 1'b0, "R5", "dependent read-go early", int'(rd_go[4]), 0);
    drain();
    chk(rd_cyc[4] == wb_cyc[3] + 1, "R5", "dependent read cycle", rd_cyc[4], wb_cyc[3] + 1);
    chk(rd_cyc[0] < rd_cyc[4], "R6", "out-of-order read", rd_cyc[0], rd_cyc[4]);

    // R7: finished adder held until the divide has read the old register 6
    lat[1] = 15; lat[4] = 2; lat[3] = 1;
    expect_wb(1, 14); expect_wb(3, 6); expect_wb(4, 15);
    do_issue(2, 14, 10, 11, 1, "R7");
    do_issue(5, 15, 14, 6, 4, "R7");
    do_issue(3, 6, 10, 11, 3, "R7");
    drain();
    chk(rd_cyc[4] == wb_cyc[1] + 1, "R7", "reader released", rd_cyc[4], wb_cyc[1] + 1);
    chk(wb_cyc[3] == rd_cyc[4] + 1, "R7", "WAR write cycle", wb_cyc[3], rd_cyc[4] + 1);

    // R8: two units finish together, lower index writes first
    lat[3] = 4; lat[0] = 3;
    expect_wb(0, 20); expect_wb(3, 21);
    do_issue(3, 21, 10, 11, 3, "R8");
    do_issue(0, 20, 10, 11, 0, "R8");
    drain();
    chk(wb_cyc[3] == wb_cyc[0] + 1, "R8", "losing unit one cycle later", wb_cyc[3], wb_cyc[0] + 1);

    // R9: issue in the very cycle the producer writes back
    lat[1] = 0; lat[3] = 2;
    expect_wb(1, 22); expect_wb(3, 23);
    do_issue(2, 22, 10, 11, 1, "R9");
    repeat (3) tick();
    man_done[1] = 1'b1;
    tick();
    man_done[1] = 1'b0;
    present(3, 23, 22, 10);
    #0.5;
    chk(wb_valid == 1'b1 && wb_fu == 3'd1, "R9", "producer writing now", int'(wb_fu), 1);
    chk(iss_grant == 1'b1, "R9", "consumer grant", int'(iss_grant), 1);
    @(posedge clk);
    #0.5;
    iss_valid = 1'b0;
    tick();
    chk(rd_go[3] == 1'b1, "R9", "consumer read-go", int'(rd_go[3]), 1);
    drain();

    // R11: completion pulses to idle and waiting units are ignored
    lat[1] = 0; lat[4] = 3;
    expect_wb(1, 24); expect_wb(4, 25);
    do_issue(2, 24, 10, 11, 1, "R11");
    do_issue(5, 25, 24, 10, 4, "R11");
    tick();
    man_done[4] = 1'b1;
    man_done[2] = 1'b1;
    tick();
    man_done = '0;
    for (int i = 0; i < 3; i++) begin
      chk(wb_valid == 1'b0, "R11", "write-back after stray completion", int'(wb_valid), 0);
      tick();
    end
    chk(rd_go[4] == 1'b0, "R11", "waiting unit still waiting", int'(rd_go[4]), 0);
    man_done[1] = 1'b1;
    tick();
    man_done = '0;
    drain();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule